// File: doc/BRIEF.md
# SPI Register-Mode Access Master

This block lets on-chip logic read or write one 8-bit register of an external data converter over SPI. The converter normally sits in conversion mode, so every access is wrapped: a one-byte entry command in its own chip-select frame, then a three-byte register frame (16-bit address, most significant byte first, then one data byte), then a three-byte frame that writes the exit register and returns the converter to conversion mode. The host side is a single request: address, write data, a write flag and a start strobe. The block answers with `busy`, a one-cycle `done`, an error flag and the read byte.

Before any SPI activity, the request is screened against the converter's register map. Writes to identification registers and reads of unmapped addresses are refused without touching the bus. A write of 0x81 to address 0x0000 resets the converter. It returns to conversion mode by itself, so the exit frame is left out. Instead a lockout counter keeps the bus quiet and the block busy for a set number of system clock cycles.

States of the controller: `ST_IDLE` waits for a start. `ST_ENTER` runs the entry frame. `ST_ACCESS` runs the register frame. `ST_LEAVE` runs the exit frame. `ST_LOCKOUT` waits out the reset quiet time. `ST_FINISH` raises `done` for one cycle. The transitions are:
- IDLE→ENTER on a permitted start.
- IDLE→FINISH on a refused start.
- ENTER→ACCESS when the entry frame ends.
- ACCESS→LEAVE when a normal frame ends.
- ACCESS→LOCKOUT when a reset-write frame ends.
- LEAVE→FINISH when the exit frame ends.
- LOCKOUT→FINISH when the counter expires.
- FINISH→IDLE unconditionally.

Top module: `regacc_spi_master`

## Requirements
- R1: A permitted access starts with a chip-select frame of exactly one byte, 0xA0.
- R2: The second frame is three bytes. The first byte is the address high byte, ORed with 0x80 for a read. The second byte is the address low byte. The third is the write data for a write, or 0x00 for a read.
- R3: For a read, `rdata` holds the byte sampled on `miso` during the third byte of the register frame, valid from `done` until the next start.
- R4: After a non-reset access, a third frame of three bytes, 0x00, 0x14, 0x01, is sent.
- R5: A write of data 0x81 to address 0x0000 sends no exit frame. `done` comes no sooner than LOCK_CYCLES clock cycles after its register frame ends, with no SPI frame in between. A write of any other data to 0x0000 is a normal access.
- R6: A write to 0x0003–0x0006, 0x000B–0x000D or any address above 0x0035 is refused: no frame, `done` with `err` high.
- R7: A read is refused (no frame, `err` high) unless the address is in 0x00–0x06, 0x0A–0x0E, 0x10–0x11, 0x14–0x26 or 0x34–0x35.
- R8: SPI mode 0, MSB first. `sclk` is low whenever `cs_n` is high, and `mosi` does not change while `sclk` is high. Each `sclk` half period is DIV_HALF clock cycles.
- R9: `cs_n` stays high for at least 2*DIV_HALF clock cycles between frames.
- R10: `busy` is high from an accepted start until `done`. `done` is a one-cycle pulse. A start while busy is ignored.
- R11: After reset, `cs_n` is high, and `sclk`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | Request was refused |
| rdata | output | 8 | Byte from the last successful read |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |

## Verification
The hardest condition to reach is the reset lockout. It only occurs when the exact write of 0x81 to address 0x0000 passes the permission screen. The bench must then show that the bus stays silent for the whole quiet window, and that a neighbouring write to the same address with other data still gets its exit frame. The stimulus issues that reset write and then, right after it, writes and reads address 0x0000 again. A slave model assembles every frame from the SPI pins, and each frame is compared against the expected sequence. A start pulse is also injected in the middle of an access, to show that it adds no frames.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_ACCESS,
        ST_LEAVE,
        ST_LOCKOUT,
        ST_FINISH
    } acc_state_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_LOW,
        EN_HIGH,
        EN_GAP
    } eng_state_t;

    localparam logic [7:0]  ENTRY_CMD  = 8'hA0;
    localparam logic [15:0] EXIT_ADDR  = 16'h0014;
    localparam logic [7:0]  EXIT_VAL   = 8'h01;
    localparam logic [15:0] RESET_ADDR = 16'h0000;
    localparam logic [7:0]  RESET_VAL  = 8'h81;
    localparam logic [7:0]  READ_FLAG  = 8'h80;
    localparam logic [15:0] TOP_REG    = 16'h0035;

endpackage

// File: rtl/regacc_addr_filter.sv
module regacc_addr_filter
    import regacc_pkg::*;
(
    input  logic [15:0] addr,
    input  logic        is_write,
    output logic        permitted
);

    logic in_map;
    logic wr_locked;
    logic rd_open;

    always_comb begin
        in_map    = (addr <= TOP_REG);
        wr_locked = ((addr >= 16'h0003) && (addr <= 16'h0006)) ||
                    ((addr >= 16'h000B) && (addr <= 16'h000D));
        rd_open   = (addr <= 16'h0006) ||
                    ((addr >= 16'h000A) && (addr <= 16'h000E)) ||
                    ((addr >= 16'h0010) && (addr <= 16'h0011)) ||
                    ((addr >= 16'h0014) && (addr <= 16'h0026)) ||
                    ((addr >= 16'h0034) && (addr <= 16'h0035));
        if (is_write) begin
            permitted = in_map && !wr_locked;
        end else begin
            permitted = rd_open;
        end
    end

endmodule

// File: rtl/regacc_shift_engine.sv
module regacc_shift_engine
    import regacc_pkg::*;
#(
    parameter int DIV_HALF   = 4,
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  long_frame,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi,
    output logic [7:0]            rx_byte,
    output logic                  frame_done
);

    localparam int GAP_CYC = 2 * DIV_HALF;
    localparam int CNT_W   = $clog2(GAP_CYC + 1);
    localparam int BIT_W   = $clog2(FRAME_BITS + 1);

    eng_state_t            st;
    logic [CNT_W-1:0]      half_cnt;
    logic [BIT_W-1:0]      bits_left;
    logic [FRAME_BITS-1:0] sreg;
    logic [7:0]            rx_q;
    logic                  sclk_q;
    logic                  cs_q;
    logic                  done_q;
    logic                  half_term;
    logic                  gap_term;

    assign half_term = (half_cnt == CNT_W'(DIV_HALF - 1));
    assign gap_term  = (half_cnt == CNT_W'(GAP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= EN_IDLE;
            half_cnt  <= '0;
            bits_left <= '0;
            sreg      <= '0;
            rx_q      <= '0;
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                EN_IDLE: begin
                    if (go) begin
                        st        <= EN_LOW;
                        cs_q      <= 1'b0;
                        sreg      <= frame_in;
                        bits_left <= long_frame ? BIT_W'(FRAME_BITS) : BIT_W'(8);
                        half_cnt  <= '0;
                    end
                end
                EN_LOW: begin
                    if (half_term) begin
                        half_cnt <= '0;
                        sclk_q   <= 1'b1;
                        rx_q     <= {rx_q[6:0], miso};
                        st       <= EN_HIGH;
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                EN_HIGH: begin
                    if (half_term) begin
                        half_cnt <= '0;
                        sclk_q   <= 1'b0;
                        if (bits_left == BIT_W'(1)) begin
                            cs_q <= 1'b1;
                            st   <= EN_GAP;
                        end else begin
                            bits_left <= bits_left - 1'b1;
                            sreg      <= {sreg[FRAME_BITS-2:0], 1'b0};
                            st        <= EN_LOW;
                        end
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                EN_GAP: begin
                    if (gap_term) begin
                        half_cnt <= '0;
                        done_q   <= 1'b1;
                        st       <= EN_IDLE;
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    assign sclk       = sclk_q;
    assign cs_n       = cs_q;
    assign mosi       = sreg[FRAME_BITS-1];
    assign rx_byte    = rx_q;
    assign frame_done = done_q;

endmodule

// File: rtl/regacc_lock_timer.sv
module regacc_lock_timer #(
    parameter int LOCK_CYCLES = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (arm) begin
            cnt     <= CNT_W'(LOCK_CYCLES - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign expired = running && (cnt == '0);

endmodule

// File: rtl/regacc_spi_master.sv
module regacc_spi_master
    import regacc_pkg::*;
#(
    parameter int DIV_HALF    = 4,
    parameter int LOCK_CYCLES = 75000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [7:0]  rdata,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);

    localparam int FRAME_BITS = 24;

    acc_state_t            state;
    acc_state_t            state_nx;
    logic [15:0]           addr_q;
    logic [7:0]            wdata_q;
    logic                  write_q;
    logic                  reset_q;
    logic                  err_q;
    logic [7:0]            rdata_q;
    logic                  permitted;
    logic                  eng_go;
    logic                  eng_long;
    logic [FRAME_BITS-1:0] eng_frame;
    logic                  eng_done;
    logic [7:0]            eng_rx;
    logic                  timer_arm;
    logic                  timer_expired;
    logic                  is_reset_req;

    regacc_addr_filter u_filter (
        .addr      (req_addr),
        .is_write  (req_write),
        .permitted (permitted)
    );

    regacc_shift_engine #(
        .DIV_HALF   (DIV_HALF),
        .FRAME_BITS (FRAME_BITS)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (eng_go),
        .long_frame (eng_long),
        .frame_in   (eng_frame),
        .miso       (miso),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .rx_byte    (eng_rx),
        .frame_done (eng_done)
    );

    regacc_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (timer_arm),
        .expired (timer_expired)
    );

    assign is_reset_req = req_write && (req_addr == RESET_ADDR) &&
                          (req_wdata == RESET_VAL);

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            reset_q <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state <= state_nx;
            if ((state == ST_IDLE) && req_start) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                reset_q <= is_reset_req;
                err_q   <= !permitted;
            end
            if ((state == ST_ACCESS) && eng_done && !write_q) begin
                rdata_q <= eng_rx;
            end
        end
    end

    // next state and frame launch
    always_comb begin
        state_nx  = state;
        eng_go    = 1'b0;
        eng_long  = 1'b0;
        eng_frame = '0;
        timer_arm = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_start) begin
                    if (permitted) begin
                        eng_go    = 1'b1;
                        eng_frame = {ENTRY_CMD, 16'h0000};
                        state_nx  = ST_ENTER;
                    end else begin
                        state_nx = ST_FINISH;
                    end
                end
            end
            ST_ENTER: begin
                if (eng_done) begin
                    eng_go    = 1'b1;
                    eng_long  = 1'b1;
                    eng_frame = {addr_q[15:8] | (write_q ? 8'h00 : READ_FLAG),
                                 addr_q[7:0],
                                 write_q ? wdata_q : 8'h00};
                    state_nx  = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (eng_done) begin
                    if (reset_q) begin
                        timer_arm = 1'b1;
                        state_nx  = ST_LOCKOUT;
                    end else begin
                        eng_go    = 1'b1;
                        eng_long  = 1'b1;
                        eng_frame = {EXIT_ADDR, EXIT_VAL};
                        state_nx  = ST_LEAVE;
                    end
                end
            end
            ST_LEAVE: begin
                if (eng_done) begin
                    state_nx = ST_FINISH;
                end
            end
            ST_LOCKOUT: begin
                if (timer_expired) begin
                    state_nx = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // host-side outputs
    always_comb begin
        busy  = (state != ST_IDLE);
        done  = (state == ST_FINISH);
        err   = err_q;
        rdata = rdata_q;
    end

endmodule

// File: rtl/regacc_checker.sv
module regacc_checker #(
    parameter int DIV_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic cs_n,
    input logic mosi
);

    localparam int GAP_CYC = 2 * DIV_HALF;
    localparam int GW      = $clog2(GAP_CYC + 1);

    logic [GW-1:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt <= GW'(GAP_CYC);
        end else if (!cs_n) begin
            high_cnt <= '0;
        end else if (high_cnt != GW'(GAP_CYC)) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                                               // R8
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));                      // R8
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (high_cnt == GW'(GAP_CYC)));                   // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R10
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);                                                // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);                                               // R10

endmodule

bind regacc_spi_master regacc_checker #(.DIV_HALF(DIV_HALF)) u_regacc_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi)
);

// File: tb/test_regacc_spi_master.sv
module test_regacc_spi_master;

    localparam int DIV_HALF = 2;
    localparam int LOCK     = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, err, sclk, cs_n, mosi;
    logic [7:0]  rdata;
    logic        miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int frames   = 0;
    int last_rise = 0;
    bit finished = 0;
    logic [7:0]  resp_byte = 8'h00;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    regacc_spi_master #(.DIV_HALF(DIV_HALF), .LOCK_CYCLES(LOCK)) i_regacc_spi_master (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: slave model rebuilding frames from the pins, compared to scoreboard
    initial begin
        logic       pcs = 1'b1;
        logic       psclk = 1'b0;
        int         nbits = 0;
        int         idx = 0;
        int         high = 1000;
        logic [23:0] sh = '0;
        logic [23:0] resp24;
        forever begin
            @(negedge clk);
            cyc++;
            resp24 = {16'h0000, resp_byte};
            if (pcs && !cs_n) begin
                if (frames > 0) chk(high >= 2 * DIV_HALF, "R9 cs_n gap", high, 2 * DIV_HALF);
                nbits = 0; idx = 0; sh = '0;
                miso = resp24[23];
            end
            if (!cs_n && !psclk && sclk) begin
                sh = {sh[22:0], mosi};
                nbits++;
            end
            if (!cs_n && psclk && !sclk) begin
                idx++;
                if (idx < 24) miso = resp24[23 - idx];
            end
            if (!pcs && cs_n) begin
                logic [31:0] got;
                frames++;
                last_rise = cyc;
                high = 0;
                got = (nbits == 8) ? {8'd1, sh[7:0], 16'h0000} : {8'(nbits / 8), sh};
                if (exp_q.size() == 0) begin
                    chk(0, "R1,R2,R4 unexpected frame", int'(got), 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R1,R2,R4,R8 frame content", int'(got), int'(e));
                end
            end
            if (cs_n) high++;
            pcs = cs_n;
            psclk = sclk;
        end
    end

    task automatic run_access(input bit w, input logic [15:0] a, input logic [7:0] d,
                              input logic [7:0] resp, input bit ok, input bit is_rst,
                              input bit extra_start, input string tag);
        int f0;
        int guard;
        f0 = frames;
        if (ok) begin
            exp_q.push_back({8'd1, 8'hA0, 16'h0000});
            exp_q.push_back({8'd3, a[15:8] | (w ? 8'h00 : 8'h80), a[7:0], w ? d : 8'h00});
            if (!is_rst) exp_q.push_back({8'd3, 8'h00, 8'h14, 8'h01});
        end
        resp_byte = resp;
        @(negedge clk);
        req_write = w; req_addr = a; req_wdata = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(busy == 1'b1, {tag, " R10 busy after start"}, busy, 1);
        guard = 0;
        while (!done && guard < 5000) begin
            if (extra_start && guard == 20) begin
                req_addr = 16'h0021; req_write = 1'b1; req_start = 1'b1;
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        req_start = 1'b0;
        chk(done == 1'b1, {tag, " R10 done seen"}, done, 1);
        chk(err == !ok, {tag, " R6,R7 err flag"}, err, !ok);
        if (ok && !w) chk(rdata == resp, {tag, " R3 read data"}, rdata, resp);
        chk(frames - f0 == (ok ? (is_rst ? 2 : 3) : 0), {tag, " R5 frame count"}, frames - f0,
            ok ? (is_rst ? 2 : 3) : 0);
        if (is_rst) chk(cyc - last_rise >= LOCK, {tag, " R5 lockout length"}, cyc - last_rise, LOCK);
        chk(exp_q.size() == 0, {tag, " R4 frames pending"}, exp_q.size(), 0);
        @(negedge clk);
        chk(!busy && !done, {tag, " R10 idle after done"}, {busy, done}, 0);
        if (extra_start) begin
            repeat (100) @(negedge clk);
            chk(frames - f0 == 3 && !busy, {tag, " R10 start while busy ignored"}, frames - f0, 3);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R11 cs_n in reset", cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R11 spi idle", {cs_n, sclk}, 2);
        chk(busy == 1'b0 && done == 1'b0, "R11 host idle", {busy, done}, 0);
        run_access(1, 16'h0020, 8'h5A, 8'h00, 1, 0, 0, "wr20");
        run_access(0, 16'h0015, 8'h00, 8'hC3, 1, 0, 0, "rd15");
        run_access(0, 16'h0034, 8'h00, 8'h3C, 1, 0, 0, "rd34");
        run_access(0, 16'h0026, 8'h00, 8'h96, 1, 0, 0, "rd26");
        run_access(0, 16'h0027, 8'h00, 8'h00, 0, 0, 0, "R7 rd27");
        run_access(0, 16'h0008, 8'h00, 8'h00, 0, 0, 0, "R7 rd08");
        run_access(0, 16'h0012, 8'h00, 8'h00, 0, 0, 0, "R7 rd12");
        run_access(1, 16'h0004, 8'h33, 8'h00, 0, 0, 0, "R6 wr04");
        run_access(1, 16'h000C, 8'h33, 8'h00, 0, 0, 0, "R6 wr0C");
        run_access(1, 16'h0036, 8'h33, 8'h00, 0, 0, 0, "R6 wr36");
        run_access(1, 16'h0035, 8'h11, 8'h00, 1, 0, 0, "wr35");
        run_access(1, 16'h0016, 8'hE7, 8'h00, 1, 0, 1, "R10 wr16");
        run_access(1, 16'h0000, 8'h81, 8'h00, 1, 1, 0, "R5 reset");
        run_access(1, 16'h0000, 8'h80, 8'h00, 1, 0, 0, "R5 wr00");
        run_access(0, 16'h0000, 8'h00, 8'h7E, 1, 0, 0, "rd00");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule